// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is the byte-wide control register that sits between a small 8-bit microcontroller core, its two timers and its two active-low external interrupt pins. It keeps the request flags for both external interrupts and both timer overflows, one trigger-mode bit per external interrupt, and the two timer run bits. Requests go out to the interrupt controller, and the run bits go out to the timers.

Each external pin passes through a synchronizer. In edge mode, a synchronized falling edge latches a request, and the vector acknowledge for that source clears it. In level mode, the request simply follows the inverted synchronized pin, and an acknowledge has no effect on it. A timer overflow strobe latches a timer request, which is cleared by that timer's acknowledge. The CPU can read the register at any time. It can write the whole byte at the register's address, or write one bit through the bit address space that maps onto the register.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset, `rdata` is 0x00, and `ext_req`, `tmr_req` and `run` are all zero.
- R2: A byte write (`sfr_wr`) with `sfr_addr` equal to 0x88 loads the register on the next clock edge. The bit layout from bit 7 down to bit 0 is: timer1 flag, timer1 run, timer0 flag, timer0 run, ext1 flag, ext1 mode, ext0 flag, ext0 mode. A byte write to any other address leaves the register unchanged.
- R3: A bit write (`bit_wr`) with `bit_addr` in 0x88..0x8F writes `bit_wdata` into bit `bit_addr[2:0]` and leaves the other bits unchanged. Bit addresses outside that range are ignored. When a byte write and a bit write arrive in the same cycle, the byte write wins.
- R4: A one-cycle pulse on `tmr_ovf[i]` sets timer flag i on the next edge, and `tmr_req[i]` follows that flag. A pulse on `ack_tmr[i]` clears the flag.
- R5: When an overflow and an acknowledge reach the same timer flag in the same cycle, the flag ends up set.
- R6: With the mode bit set to 1 (edge mode), a falling edge on `ext_n[i]` sets ext flag i. With the default two synchronizer stages, the flag becomes visible after the third clock edge that samples the low pin. `ack_ext[i]` clears the flag. A pin that stays low does not set the flag again.
- R7: With the mode bit at 0 (level mode), ext flag i reads as the inverted pin, two edges late. `ack_ext[i]` has no effect on it, and CPU writes to that flag do not change what is read.
- R8: A CPU write to a flag bit takes priority over a hardware set or clear of that bit in the same cycle.
- R9: The two run bits drive `run[1:0]`, and they never raise a request. `ext_req` and `tmr_req` always equal their flag bits in `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n | input | 2 | Active-low external interrupt pins |
| tmr_ovf | input | 2 | Timer overflow strobes |
| ack_ext | input | 2 | Vector acknowledge for the external sources |
| ack_tmr | input | 2 | Vector acknowledge for the timer sources |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_addr | input | 8 | Byte write address |
| sfr_wdata | input | 8 | Byte write data |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_addr | input | 8 | Bit address |
| bit_wdata | input | 1 | Single-bit write data |
| rdata | output | 8 | Register read value |
| ext_req | output | 2 | External interrupt requests |
| tmr_req | output | 2 | Timer interrupt requests |
| run | output | 2 | Timer run bits |

## Verification
The bench builds the block with its default parameters: register address 0x88 and two synchronizer stages. These values fix the bit address window at 0x88..0x8F, which lets the bench test in-window and out-of-window bit writes. They also put the edge-mode latency at three clock edges and the level-mode latency at two. The bench therefore checks a flag's value on the cycle just before it changes and on the cycle it changes. Same-cycle collisions are driven deliberately: overflow against acknowledge, a CPU write against hardware set and clear, and a byte write against a bit write.

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter logic [7:0] REG_ADDR    = 8'h88,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ext_n,
  input  logic [1:0] tmr_ovf,
  input  logic [1:0] ack_ext,
  input  logic [1:0] ack_tmr,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  input  logic       bit_wr,
  input  logic [7:0] bit_addr,
  input  logic       bit_wdata,
  output logic [7:0] rdata,
  output logic [1:0] ext_req,
  output logic [1:0] tmr_req,
  output logic [1:0] run
);
  localparam logic [4:0] BIT_BASE = REG_ADDR[7:3];

  logic [7:0] q, q_d, wmask, wval, hw_set, hw_clr;
  logic [1:0] fall, lvl;

  wire byte_hit = sfr_wr && (sfr_addr == REG_ADDR);
  wire bit_hit  = bit_wr && (bit_addr[7:3] == BIT_BASE) && !byte_hit;

  assign wmask = byte_hit ? 8'hFF : (bit_hit ? (8'h01 << bit_addr[2:0]) : 8'h00);
  assign wval  = byte_hit ? sfr_wdata : {8{bit_wdata}};

  for (genvar i = 0; i < 2; i++) begin : g_src
    logic [SYNC_STAGES:0] sh;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sh <= '1;
      else        sh <= {sh[SYNC_STAGES-1:0], ext_n[i]};
    assign fall[i] = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];
    assign lvl[i]  = ~sh[SYNC_STAGES-1];

    assign hw_set[2*i]   = 1'b0;
    assign hw_clr[2*i]   = 1'b0;
    assign hw_set[2*i+1] = fall[i] & q[2*i];
    assign hw_clr[2*i+1] = ack_ext[i] & q[2*i];
    assign hw_set[2*i+4] = 1'b0;
    assign hw_clr[2*i+4] = 1'b0;
    assign hw_set[2*i+5] = tmr_ovf[i];
    assign hw_clr[2*i+5] = ack_tmr[i];

    assign ext_req[i] = rdata[2*i+1];
    assign tmr_req[i] = q[2*i+5];
    assign run[i]     = q[2*i+4];
  end

  always_comb
    for (int b = 0; b < 8; b++)
      q_d[b] = wmask[b] ? wval[b] : (hw_set[b] ? 1'b1 : (hw_clr[b] ? 1'b0 : q[b]));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= 8'h00;
    else        q <= q_d;

  assign rdata = {q[7:4],
                  q[2] ? q[3] : lvl[1], q[2],
                  q[0] ? q[1] : lvl[0], q[0]};

  // R4
  tf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ovf[0] && !sfr_wr && !bit_wr) |=> tmr_req[0]);
  // R4
  tf_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_tmr[0] && !tmr_ovf[0] && !sfr_wr && !bit_wr) |=> !tmr_req[0]);
  // R5
  tf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ovf[1] && ack_tmr[1] && !sfr_wr && !bit_wr) |=> tmr_req[1]);
  // R2
  byte_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == REG_ADDR) |=>
      (rdata[7:4] == $past(sfr_wdata[7:4]) && rdata[2] == $past(sfr_wdata[2])
       && rdata[0] == $past(sfr_wdata[0])));
  // R6
  ie_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q[0] && ack_ext[0] && !fall[0] && !sfr_wr && !bit_wr) |=> !ext_req[0]);
endmodule

// File: tb/irq_flag_reg_tb.sv
`timescale 1ns/1ps
module irq_flag_reg_tb_top;
  logic clk = 0, rst_n = 0;
  logic [1:0] ext_n = 2'b11, tmr_ovf = 0, ack_ext = 0, ack_tmr = 0;
  logic sfr_wr = 0, bit_wr = 0, bit_wdata = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, bit_addr = 0;
  logic [7:0] rdata;
  logic [1:0] ext_req, tmr_req, run;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  typedef struct { string tag; logic [7:0] exp; } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  irq_flag_reg dut_i (.clk, .rst_n, .ext_n, .tmr_ovf, .ack_ext, .ack_tmr,
    .sfr_wr, .sfr_addr, .sfr_wdata, .bit_wr, .bit_addr, .bit_wdata,
    .rdata, .ext_req, .tmr_req, .run);

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [7:0] e;
      it = sbq.pop_front();
      e = it.exp;
      n_chk++;
      if (rdata !== e || ext_req !== {e[3], e[1]} || tmr_req !== {e[7], e[5]}
          || run !== {e[6], e[4]}) begin
        n_err++;
        $display("FAIL %s: rdata=%h ext_req=%b tmr_req=%b run=%b expected rdata=%h",
                 it.tag, rdata, ext_req, tmr_req, run, e);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic expect_rd(string tag, logic [7:0] e);
    item_t it;
    it.tag = tag; it.exp = e;
    sbq.push_back(it);
  endtask
  task automatic idle();
    sfr_wr = 0; bit_wr = 0; tmr_ovf = 0; ack_ext = 0; ack_tmr = 0;
  endtask
  task automatic wr_byte(logic [7:0] a, logic [7:0] d);
    sfr_wr = 1; sfr_addr = a; sfr_wdata = d; tick(); idle();
  endtask
  task automatic wr_bit(logic [7:0] a, logic d);
    bit_wr = 1; bit_addr = a; bit_wdata = d; tick(); idle();
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    tick(2); rst_n = 1; tick();
    expect_rd("R1 reset value", 8'h00);
    tick();
    wr_byte(8'h88, 8'h55); expect_rd("R2 byte write", 8'h55);
    wr_byte(8'h89, 8'hFF); expect_rd("R2 other address ignored", 8'h55);
    wr_bit(8'h8D, 1);      expect_rd("R3 bit write sets timer0 flag", 8'h75);
    wr_bit(8'h8D, 0);      expect_rd("R3 bit write clears", 8'h55);
    wr_bit(8'h90, 1);      expect_rd("R3 out-of-window bit ignored", 8'h55);
    sfr_wr = 1; sfr_addr = 8'h88; sfr_wdata = 8'h55; bit_wr = 1; bit_addr = 8'h8F; bit_wdata = 1;
    tick(); idle();        expect_rd("R3 byte beats bit write", 8'h55);
    tmr_ovf = 2'b10; tick(); idle(); expect_rd("R4 timer1 overflow", 8'hD5);
    ack_tmr = 2'b10; tick(); idle(); expect_rd("R4 timer1 ack clears", 8'h55);
    tmr_ovf = 2'b01; ack_tmr = 2'b01; tick(); idle(); expect_rd("R5 set beats ack", 8'h75);
    ack_tmr = 2'b01; tick(); idle(); expect_rd("R4 timer0 ack clears", 8'h55);
    tmr_ovf = 2'b10; bit_wr = 1; bit_addr = 8'h8F; bit_wdata = 0;
    tick(); idle();        expect_rd("R8 write beats hw set", 8'h55);
    tmr_ovf = 2'b01; tick(); idle(); expect_rd("R4 timer0 set", 8'h75);
    ack_tmr = 2'b01; bit_wr = 1; bit_addr = 8'h8D; bit_wdata = 1;
    tick(); idle();        expect_rd("R8 write beats hw clear", 8'h75);
    ack_tmr = 2'b01; tick(); idle(); expect_rd("R4 clear again", 8'h55);
    // R6 edge mode on ext0
    ext_n[0] = 0; tick(2); expect_rd("R6 not yet visible", 8'h55);
    tick();                expect_rd("R6 edge sets flag", 8'h57);
    ack_ext = 2'b01; tick(); idle(); expect_rd("R6 ack clears", 8'h55);
    tick(4);               expect_rd("R6 held low no re-set", 8'h55);
    ext_n[0] = 1; tick(4); ext_n[0] = 0; tick(3);
    expect_rd("R6 second edge", 8'h57);
    wr_bit(8'h89, 0);      expect_rd("R3 bit clear of ext0 flag", 8'h55);
    ext_n[0] = 1; tick(4);
    // R7 level mode on ext1
    wr_bit(8'h8A, 0);      expect_rd("R7 ext1 to level mode", 8'h51);
    ext_n[1] = 0; tick();  expect_rd("R7 level one edge in", 8'h51);
    tick();                expect_rd("R7 level follows pin", 8'h59);
    ack_ext = 2'b10; tick(); idle(); expect_rd("R7 ack ignored", 8'h59);
    wr_bit(8'h8B, 0);      expect_rd("R7 write ignored on read", 8'h59);
    ext_n[1] = 1; tick(2); expect_rd("R7 pin released", 8'h51);
    // R9 run bits
    wr_byte(8'h88, 8'h50); expect_rd("R9 run bits out, no requests", 8'h50);
    wr_byte(8'h88, 8'h00); expect_rd("R9 run bits cleared", 8'h00);
    tick(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule